// File: doc/BRIEF.md
# Masked Packed Word-to-Byte Narrowing Unit

This block narrows a vector of packed 16-bit lanes into a vector of packed 8-bit lanes. Each conversion request chooses one of three narrowing rules: keep the low byte, clamp as a signed value, or clamp as an unsigned value. The request also picks how many source lanes take part (8, 16 or 32, that is 128, 256 or 512 source bits). A per-lane write mask decides which result bytes are produced. Lanes that the mask leaves out either keep the previous destination byte or become zero.

A request goes to one of two destination kinds. A register destination gives a full 512-bit result in which everything above the produced bytes is cleared. A memory destination gives a 256-bit data bus with one enable per byte, so lanes that are not selected are simply not written. A non-zero reserved specifier, an illegal length code or an unknown mode code raises a fault, and the fault suppresses the result. All results are registered and appear one cycle after the input strobe.

Top module: `wnarrow_unit`

## Requirements
- R1: Result byte j (bits 8j+7..8j) comes from source word j (bits 16j+15..16j). `len_sel` 0, 1 and 2 select 8, 16 and 32 active lanes.
- R2: Mode code 8'h30 truncates: the result byte is the low 8 bits of the word.
- R3: Mode code 8'h20 treats the word as signed and clamps it to -128..127 (8'h80..8'h7F).
- R4: Mode code 8'h10 treats the word as unsigned: values above 255 become 8'hFF, other values pass unchanged.
- R5: For a register destination, an active lane takes the converted byte when `mask_en` is 0 or its `lane_mask` bit is 1. Otherwise it takes the `old_dst` byte when `zero_mask` is 0, or 8'h00 when `zero_mask` is 1.
- R6: For a register destination, every `reg_result` bit from 8×(active lanes) up to bit 511 is zero.
- R7: For a memory destination, `mem_byte_en[j]` is 1 exactly when lane j is active and (`mask_en` is 0 or `lane_mask[j]` is 1). `zero_mask` has no effect. `mem_data` byte j holds the converted byte for active lanes and zero for all others. `reg_result` keeps its value.
- R8: A `rsvd_field` value other than 4'hF sets `fault`. It leaves `reg_result` and `mem_data` unchanged and clears `mem_byte_en`.
- R9: `len_sel` 3, or a mode code other than 8'h30, 8'h20 or 8'h10, sets `fault` with the same suppression as R8.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The results of that request are present in that same cycle.
- R11: During and after reset, before any request, all outputs are zero.
- R12: A legal request clears `fault`. A register-destination request clears `mem_byte_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 512 | Packed 16-bit source lanes |
| old_dst | input | 256 | Previous destination bytes, used for merging |
| lane_mask | input | 32 | Per-lane write mask |
| mask_en | input | 1 | 1 = apply lane_mask |
| zero_mask | input | 1 | Register destination: 1 = zero the unselected lanes |
| mode_code | input | 8 | Narrowing rule code |
| len_sel | input | 2 | Active lane count select |
| dst_mem | input | 1 | 1 = memory destination, 0 = register destination |
| rsvd_field | input | 4 | Reserved specifier, must be 4'hF |
| out_valid | output | 1 | Result strobe |
| reg_result | output | 512 | Register destination result |
| mem_data | output | 256 | Memory destination data |
| mem_byte_en | output | 32 | Memory destination byte enables |
| fault | output | 1 | Illegal encoding flag |

## Verification
Every result is due exactly one cycle after its strobe: `out_valid`, `fault`, `reg_result`, `mem_data` and `mem_byte_en` are all loaded on the clock edge that samples `in_valid`. The bench drives a request on a falling edge and checks all five outputs on the next falling edge, after the single register stage has been loaded. After each request it leaves one idle cycle and confirms there that `out_valid` has dropped. The bench keeps its own copy of the destination state, so merge lanes and suppressed writes are compared against the values that the earlier requests left behind.

// File: rtl/wn_pkg.sv
package wn_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [7:0] {
    MODE_TRUNC = 8'h30,
    MODE_SSAT  = 8'h20,
    MODE_USAT  = 8'h10
  } mode_e;

  typedef enum logic [1:0] {
    LEN_Q   = 2'd0,
    LEN_H   = 2'd1,
    LEN_F   = 2'd2,
    LEN_BAD = 2'd3
  } len_e;

  typedef enum logic [1:0] {
    CV_TRUNC = 2'd0,
    CV_SSAT  = 2'd1,
    CV_USAT  = 2'd2
  } cv_e;
endpackage

// File: rtl/wn_decode.sv
module wn_decode
  import wn_pkg::*;
#(
  parameter int NLANES = 32,
  parameter int RSVD_W = 4
) (
  input  logic [7:0]        mode_code,
  input  logic [1:0]        len_sel,
  input  logic [RSVD_W-1:0] rsvd_field,
  output cv_e               cv_kind,
  output logic [NLANES-1:0] lane_on,
  output logic              fault
);
  localparam int CNT_W     = $clog2(NLANES) + 1;
  localparam int MIN_LANES = NLANES / 4;

  logic [CNT_W-1:0] lane_cnt;
  logic             len_ok;
  logic             mode_ok;

  always_comb begin
    len_ok   = 1'b1;
    lane_cnt = '0;
    case (len_sel)
      LEN_Q:   lane_cnt = CNT_W'(MIN_LANES);
      LEN_H:   lane_cnt = CNT_W'(MIN_LANES * 2);
      LEN_F:   lane_cnt = CNT_W'(MIN_LANES * 4);
      default: len_ok   = 1'b0;
    endcase
  end

  always_comb begin
    mode_ok = 1'b1;
    cv_kind = CV_TRUNC;
    case (mode_code)
      MODE_TRUNC: cv_kind = CV_TRUNC;
      MODE_SSAT:  cv_kind = CV_SSAT;
      MODE_USAT:  cv_kind = CV_USAT;
      default:    mode_ok = 1'b0;
    endcase
  end

  assign fault = !len_ok || !mode_ok || (rsvd_field != {RSVD_W{1'b1}});

  for (genvar j = 0; j < NLANES; j++) begin : g_on
    assign lane_on[j] = !fault && (CNT_W'(j) < lane_cnt);
  end
endmodule

// File: rtl/wn_lane_conv.sv
module wn_lane_conv
  import wn_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  word_i,
  input  cv_e              cv_kind,
  output logic [OUT_W-1:0] byte_o
);
  logic [IN_W-OUT_W:0]   sign_run;
  logic [IN_W-OUT_W-1:0] high_part;
  logic                  s_fits;

  assign sign_run  = word_i[IN_W-1:OUT_W-1];
  assign high_part = word_i[IN_W-1:OUT_W];
  assign s_fits    = (&sign_run) || !(|sign_run);

  always_comb begin
    byte_o = word_i[OUT_W-1:0];
    case (cv_kind)
      CV_SSAT: begin
        if (!s_fits)
          byte_o = word_i[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                  : {1'b0, {(OUT_W-1){1'b1}}};
      end
      CV_USAT: begin
        if (|high_part) byte_o = {OUT_W{1'b1}};
      end
      default: byte_o = word_i[OUT_W-1:0];
    endcase
  end
endmodule

// File: rtl/wn_lane_merge.sv
module wn_lane_merge #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] conv_byte,
  input  logic [BW-1:0] old_byte,
  input  logic          lane_on,
  input  logic          sel,
  input  logic          mask_en,
  input  logic          zero_mask,
  output logic [BW-1:0] reg_byte,
  output logic [BW-1:0] mem_byte,
  output logic          mem_en
);
  logic take;

  assign take = lane_on && (!mask_en || sel);

  always_comb begin
    if (!lane_on)       reg_byte = '0;
    else if (take)      reg_byte = conv_byte;
    else if (zero_mask) reg_byte = '0;
    else                reg_byte = old_byte;
  end

  assign mem_en   = take;
  assign mem_byte = lane_on ? conv_byte : '0;
endmodule

// File: rtl/wnarrow_unit.sv
module wnarrow_unit
  import wn_pkg::*;
#(
  parameter int SRC_W  = 512,
  parameter int RSVD_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [SRC_W-1:0]             src_vec,
  input  logic [SRC_W/2-1:0]           old_dst,
  input  logic [SRC_W/WORD_W-1:0]      lane_mask,
  input  logic                         mask_en,
  input  logic                         zero_mask,
  input  logic [7:0]                   mode_code,
  input  logic [1:0]                   len_sel,
  input  logic                         dst_mem,
  input  logic [RSVD_W-1:0]            rsvd_field,
  output logic                         out_valid,
  output logic [SRC_W-1:0]             reg_result,
  output logic [SRC_W/2-1:0]           mem_data,
  output logic [SRC_W/WORD_W-1:0]      mem_byte_en,
  output logic                         fault
);
  localparam int NLANES = SRC_W / WORD_W;
  localparam int OUT_W  = NLANES * BYTE_W;

  cv_e               cv_kind;
  logic [NLANES-1:0] lane_on;
  logic              fault_c;
  logic [OUT_W-1:0]  reg_bytes;
  logic [OUT_W-1:0]  mem_bytes;
  logic [NLANES-1:0] en_c;

  wn_decode #(.NLANES(NLANES), .RSVD_W(RSVD_W)) u_dec (
    .mode_code  (mode_code),
    .len_sel    (len_sel),
    .rsvd_field (rsvd_field),
    .cv_kind    (cv_kind),
    .lane_on    (lane_on),
    .fault      (fault_c)
  );

  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    logic [BYTE_W-1:0] conv_b;

    wn_lane_conv #(.IN_W(WORD_W), .OUT_W(BYTE_W)) u_conv (
      .word_i  (src_vec[j*WORD_W +: WORD_W]),
      .cv_kind (cv_kind),
      .byte_o  (conv_b)
    );

    wn_lane_merge #(.BW(BYTE_W)) u_merge (
      .conv_byte (conv_b),
      .old_byte  (old_dst[j*BYTE_W +: BYTE_W]),
      .lane_on   (lane_on[j]),
      .sel       (lane_mask[j]),
      .mask_en   (mask_en),
      .zero_mask (zero_mask),
      .reg_byte  (reg_bytes[j*BYTE_W +: BYTE_W]),
      .mem_byte  (mem_bytes[j*BYTE_W +: BYTE_W]),
      .mem_en    (en_c[j])
    );
  end

  // next-state
  logic              valid_d;
  logic [SRC_W-1:0]  reg_d;
  logic [OUT_W-1:0]  mem_d;
  logic [NLANES-1:0] en_d;
  logic              fault_d;
  logic              reg_we;
  logic              mem_we;

  assign reg_we = in_valid && !fault_c && !dst_mem;
  assign mem_we = in_valid && !fault_c && dst_mem;

  always_comb begin
    valid_d = in_valid;
    reg_d   = reg_result;
    mem_d   = mem_data;
    en_d    = mem_byte_en;
    fault_d = fault;
    if (in_valid) begin
      fault_d = fault_c;
      en_d    = mem_we ? en_c : '0;
    end
    if (reg_we) begin
      reg_d            = '0;
      reg_d[OUT_W-1:0] = reg_bytes;
    end
    if (mem_we) mem_d = mem_bytes;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      reg_result  <= '0;
      mem_data    <= '0;
      mem_byte_en <= '0;
      fault       <= 1'b0;
    end else begin
      out_valid <= valid_d;
      if (in_valid) begin
        reg_result  <= reg_d;
        mem_data    <= mem_d;
        mem_byte_en <= en_d;
        fault       <= fault_d;
      end
    end
  end
endmodule

// File: rtl/wn_narrow_chk.sv
module wn_narrow_chk #(
  parameter int SRC_W = 512
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [1:0]              len_sel,
  input logic                    dst_mem,
  input logic                    out_valid,
  input logic [SRC_W-1:0]        reg_result,
  input logic [SRC_W/2-1:0]      mem_data,
  input logic [SRC_W/16-1:0]     mem_byte_en,
  input logic                    fault
);
  localparam int NL = SRC_W / 16;

  assert_upper_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_result[SRC_W-1:SRC_W/2] == '0);

  assert_valid_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_fault_no_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fault) |-> (mem_byte_en == '0));

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fault) |-> ($stable(reg_result) && $stable(mem_data)));

  assert_bad_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(len_sel) == 2'd3) |-> fault);

  assert_short_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(len_sel) == 2'd0) |-> (mem_byte_en[NL-1:NL/4] == '0));

  assert_mem_keeps_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(dst_mem)) |-> $stable(reg_result));
endmodule

bind wnarrow_unit wn_narrow_chk #(.SRC_W(SRC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .len_sel     (len_sel),
  .dst_mem     (dst_mem),
  .out_valid   (out_valid),
  .reg_result  (reg_result),
  .mem_data    (mem_data),
  .mem_byte_en (mem_byte_en),
  .fault       (fault)
);

// File: tb/wnarrow_unit_tb.sv
module wnarrow_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [511:0] src_vec;
  logic [255:0] old_dst;
  logic [31:0]  lane_mask;
  logic         mask_en;
  logic         zero_mask;
  logic [7:0]   mode_code;
  logic [1:0]   len_sel;
  logic         dst_mem;
  logic [3:0]   rsvd_field;
  logic         out_valid;
  logic [511:0] reg_result;
  logic [255:0] mem_data;
  logic [31:0]  mem_byte_en;
  logic         fault;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [511:0] e_reg;
  logic [255:0] e_mem;
  logic [31:0]  e_en;
  logic         e_fault;

  always #5 clk = ~clk;

  wnarrow_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .old_dst(old_dst), .lane_mask(lane_mask), .mask_en(mask_en),
    .zero_mask(zero_mask), .mode_code(mode_code), .len_sel(len_sel),
    .dst_mem(dst_mem), .rsvd_field(rsvd_field), .out_valid(out_valid),
    .reg_result(reg_result), .mem_data(mem_data), .mem_byte_en(mem_byte_en),
    .fault(fault)
  );

  task automatic chk(string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] nconv(logic [7:0] m, logic [15:0] w);
    int v;
    case (m)
      8'h20: begin
        v = int'($signed(w));
        if (v > 127) return 8'h7F;
        if (v < -128) return 8'h80;
        return w[7:0];
      end
      8'h10: begin
        v = int'(w);
        return (v > 255) ? 8'hFF : w[7:0];
      end
      default: return w[7:0];
    endcase
  endfunction

  task automatic model();
    int lanes;
    logic [511:0] r;
    lanes = (len_sel == 2'd0) ? 8 : (len_sel == 2'd1) ? 16 : (len_sel == 2'd2) ? 32 : 0;
    if (lanes == 0 || rsvd_field != 4'hF ||
        !(mode_code == 8'h30 || mode_code == 8'h20 || mode_code == 8'h10)) begin
      e_fault = 1'b1;
      e_en    = '0;
      return;
    end
    e_fault = 1'b0;
    if (dst_mem) begin
      e_mem = '0;
      e_en  = '0;
      for (int j = 0; j < lanes; j++) begin
        e_mem[j*8 +: 8] = nconv(mode_code, src_vec[j*16 +: 16]);
        e_en[j] = !mask_en || lane_mask[j];
      end
    end else begin
      r = '0;
      for (int j = 0; j < lanes; j++) begin
        if (!mask_en || lane_mask[j]) r[j*8 +: 8] = nconv(mode_code, src_vec[j*16 +: 16]);
        else if (!zero_mask)          r[j*8 +: 8] = old_dst[j*8 +: 8];
      end
      e_reg = r;
      e_en  = '0;
    end
  endtask

  // called at a falling edge with the inputs already set
  task automatic run_op(string req);
    in_valid = 1'b1;
    model();
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "out_valid", 512'(out_valid), 512'(1'b1));
    chk(req, "fault", 512'(fault), 512'(e_fault));
    chk(req, "reg_result", reg_result, e_reg);
    chk(req, "mem_data", 512'(mem_data), 512'(e_mem));
    chk(req, "mem_byte_en", 512'(mem_byte_en), 512'(e_en));
    @(negedge clk);
    chk("R10", "out_valid idle", 512'(out_valid), 512'(1'b0));
  endtask

  task automatic set_op(logic [7:0] m, logic [1:0] l, logic dm, logic me,
                        logic zm, logic [31:0] msk, logic [3:0] rv);
    mode_code = m; len_sel = l; dst_mem = dm; mask_en = me;
    zero_mask = zm; lane_mask = msk; rsvd_field = rv;
  endtask

  function automatic logic [511:0] rnd_src();
    logic [511:0] s;
    for (int j = 0; j < 32; j++) begin
      if ($urandom % 2 == 0) s[j*16 +: 16] = 16'($urandom);
      else s[j*16 +: 16] = 16'(int'($urandom % 600) - 300);
    end
    return s;
  endfunction

  function automatic logic [255:0] rnd_old();
    logic [255:0] s;
    for (int j = 0; j < 8; j++) s[j*32 +: 32] = $urandom;
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; in_valid = 1'b0; src_vec = '0; old_dst = '0;
    set_op(8'h30, 2'd2, 1'b0, 1'b0, 1'b0, '0, 4'hF);
    e_reg = '0; e_mem = '0; e_en = '0; e_fault = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "reset out_valid", 512'(out_valid), '0);
    chk("R11", "reset reg_result", reg_result, '0);
    chk("R11", "reset mem_byte_en", 512'({mem_byte_en, fault}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "after reset mem_data", 512'(mem_data), '0);

    // R1 R2: lane order, truncation, full length
    for (int j = 0; j < 32; j++) src_vec[j*16 +: 16] = 16'h1200 + 16'(j);
    set_op(8'h30, 2'd2, 1'b0, 1'b0, 1'b0, '0, 4'hF);
    run_op("R1 R2");

    // R3 signed clamp corners
    src_vec = '0;
    src_vec[0*16 +: 16] = 16'h0080; src_vec[1*16 +: 16] = 16'hFF7F;
    src_vec[2*16 +: 16] = 16'h007F; src_vec[3*16 +: 16] = 16'hFF80;
    src_vec[4*16 +: 16] = 16'h8000; src_vec[5*16 +: 16] = 16'h7FFF;
    src_vec[6*16 +: 16] = 16'hFFFF; src_vec[7*16 +: 16] = 16'h0001;
    set_op(8'h20, 2'd0, 1'b0, 1'b0, 1'b0, '0, 4'hF);
    run_op("R3");
    chk("R3", "0x0080 clamps", 512'(reg_result[7:0]), 512'(8'h7F));

    // R4 unsigned clamp corners
    src_vec[0*16 +: 16] = 16'h0100; src_vec[1*16 +: 16] = 16'h00FF;
    src_vec[2*16 +: 16] = 16'h8000; src_vec[3*16 +: 16] = 16'h0005;
    set_op(8'h10, 2'd1, 1'b0, 1'b0, 1'b0, '0, 4'hF);
    run_op("R4");

    // R5 merge and zero masking, R6 upper clear
    old_dst = '1;
    src_vec = rnd_src();
    set_op(8'h30, 2'd0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FF55, 4'hF);
    run_op("R5 R6 merge");
    set_op(8'h20, 2'd1, 1'b0, 1'b1, 1'b1, 32'h0000_A5A5, 4'hF);
    run_op("R5 R6 zero");

    // R7 memory destination, zeroing flag ignored
    set_op(8'h10, 2'd0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FF0F, 4'hF);
    run_op("R7");
    chk("R7", "upper enables off", 512'(mem_byte_en[31:8]), '0);

    // R8 R9 faults
    src_vec = rnd_src();
    set_op(8'h30, 2'd2, 1'b0, 1'b0, 1'b0, '0, 4'hE);
    run_op("R8");
    set_op(8'h30, 2'd3, 1'b1, 1'b0, 1'b0, '0, 4'hF);
    run_op("R9 len");
    set_op(8'h40, 2'd2, 1'b1, 1'b0, 1'b0, '0, 4'hF);
    run_op("R9 mode");
    // R12: a legal request clears the fault flag and the enables
    set_op(8'h30, 2'd2, 1'b0, 1'b0, 1'b0, '0, 4'hF);
    run_op("R12");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] m;
      int pick;
      src_vec = rnd_src();
      old_dst = rnd_old();
      pick = int'($urandom % 16);
      m = (pick < 5) ? 8'h30 : (pick < 10) ? 8'h20 : (pick < 15) ? 8'h10 : 8'($urandom);
      set_op(m, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), $urandom,
             ($urandom % 10 == 0) ? 4'($urandom) : 4'hF);
      if (m == 8'h20) run_op("R3");
      else if (m == 8'h10) run_op("R4");
      else if (m == 8'h30) run_op("R2");
      else run_op("R9");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule